// File: doc/BRIEF.md
# Write-Through Set-Associative Data Cache

This block is a small data cache placed between a processor load/store port and a word-wide memory port with a request/acknowledge handshake. The number of sets, ways and 32-bit words per line are parameters. Each address splits into a byte offset within the line, a set index and a tag. The tag is compared against every valid way of the selected set. A read miss refills a whole line, and the refill starts with the word that was asked for. A store is always written to memory. A store miss first writes memory and then allocates the line, so the refilled copy already holds the stored data. Byte and halfword accesses pick their lanes in big-endian order.

A per-set tracker of recency counters chooses the way to replace. The processor raises a request and then sees `cpu_busy` until the access finishes. `cpu_done` pulses for one cycle, with read data valid in that same cycle. A request can instead ask to invalidate one line. When the cache is switched off, that request clears the whole indexed set. When the cache is disabled, or an access is marked as not cacheable, reads and writes go directly to memory and leave the arrays as they were. A constant output reports the geometry.

Top module: `dcwt_cache`

## Requirements
- R1: The set index is (address / line_bytes) mod NSETS and the tag is (address / line_bytes) / NSETS. An access counts as a hit only when a valid way of that set holds the tag. A hit makes no memory read.
- R2: When `cpu_en` is 0, `cpu_inhibit` is 1, or the parameter PRESENT is 0, a read makes exactly one memory read of the word-aligned address and changes no cache state. Lines cached before such an access still hit afterwards.
- R3: Every store, hit or miss, cached or not, makes exactly one memory write. `mem_be[3]` selects bits 31:24 and `mem_be[0]` selects bits 7:0.
- R4: A cacheable store miss first writes memory and then refills a victim line. A later read of the same address hits and returns the stored value.
- R5: A refill reads LW words. It starts at the word-aligned requested address and wraps modulo the line size. `mem_req` stays high with a stable address until `mem_ack`.
- R6: `cpu_size` is 0 for a byte, 1 for a halfword and 2 for a word. A halfword occupies bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1. A byte sits at right shift 8*(3 - addr[1:0]). Read data is zero-extended.
- R7: A store hit changes only the addressed byte or halfword lanes of the cached word.
- R8: An invalidate whose tag hits clears that way's valid bit and zeroes its recency counter. Other ways are left unchanged. An invalidate that misses has no effect.
- R9: An invalidate issued with `cpu_en` 0 clears every way of the indexed set and leaves other sets unchanged.
- R10: `cfg_info` returns log2(NWAYS) in bits 2:0 and log2(NSETS) in bits 6:3. All other bits are 0.
- R11: After reset no way is valid, so the first access to any line misses.
- R12: Each way of a set keeps a recency counter with USTATES levels. A hit raises the used way to the top and decrements every way above its old value. A fill raises the victim to the top and decrements every other nonzero counter. The victim is the lowest-numbered way with the smallest counter.
- R13: After reset `cpu_busy`, `cpu_done` and `mem_req` are 0. `cpu_busy` is 1 from the cycle after a request is accepted until the access completes. `cpu_done` is a one-cycle pulse, is never high together with `cpu_busy`, and carries `cpu_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, taken when the block is idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_inv | input | 1 | Invalidate the line at cpu_addr instead of accessing it |
| cpu_en | input | 1 | Cache enable |
| cpu_inhibit | input | 1 | Access is not cacheable |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Store data, right-aligned |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, zero-extended |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one per word |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| cfg_info | output | 32 | Geometry report |

## Verification
The bench checks the refill address sequence against the wrapped order. A cache that refilled from word 0 would deliver the wrong critical word and would fail the order check. It counts memory reads per access. An extra read exposes a missing hit, an invalidate or bypass that touched the wrong state, or a victim picked against recency order, for example the most recently hit line being evicted. Sub-word stores on a hit are read back as full words to catch merges that disturb other lanes. Swapped big-endian lanes show up as wrong byte enables or wrong extracted data. Invalidating while disabled is checked both in the indexed set, where every way must miss afterwards, and in a neighbouring set, which must keep hitting.

// File: rtl/dcwt_pkg.sv
package dcwt_pkg;

   typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;

   typedef enum logic [2:0] {
      LRU_NONE, LRU_HIT, LRU_FILL, LRU_CLR_WAY, LRU_CLR_SET
   } lru_op_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LOOK, ST_MRD, ST_MWR, ST_FILL, ST_RESP
   } state_e;

   // byte enables, bit 3 = most significant lane
   function automatic logic [3:0] lane_be(input logic [1:0] a, input logic [1:0] sz);
      case (sz)
         SZ_BYTE: lane_be = 4'b1000 >> a;
         SZ_HALF: lane_be = a[1] ? 4'b0011 : 4'b1100;
         default: lane_be = 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      lane_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

   function automatic logic [31:0] lane_put(input logic [31:0] d, input logic [1:0] sz);
      case (sz)
         SZ_BYTE: lane_put = {4{d[7:0]}};
         SZ_HALF: lane_put = {2{d[15:0]}};
         default: lane_put = d;
      endcase
   endfunction

   function automatic logic [31:0] lane_get(input logic [31:0] w, input logic [1:0] a,
                                            input logic [1:0] sz);
      logic [31:0] sh;
      sh = w >> (5'd8 * (5'd3 - {3'd0, a}));
      case (sz)
         SZ_BYTE: lane_get = {24'd0, sh[7:0]};
         SZ_HALF: lane_get = a[1] ? {16'd0, w[15:0]} : {16'd0, w[31:16]};
         default: lane_get = w;
      endcase
   endfunction

endpackage

// File: rtl/dcwt_arrays.sv
module dcwt_arrays #(
   parameter int NSETS = 4,
   parameter int NWAYS = 2,
   parameter int LW    = 4,
   parameter int TAG_W = 26,
   localparam int IDX_W = $clog2(NSETS),
   localparam int WAY_W = $clog2(NWAYS),
   localparam int WO_W  = $clog2(LW)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [IDX_W-1:0]             idx,
   input  logic [WO_W-1:0]              wofs,
   output logic [NWAYS-1:0][TAG_W-1:0]  way_tag,
   output logic [NWAYS-1:0]             way_vld,
   output logic [NWAYS-1:0][31:0]       way_word,
   input  logic                         dwr_en,
   input  logic [WAY_W-1:0]             dwr_way,
   input  logic [WO_W-1:0]              dwr_wofs,
   input  logic [31:0]                  dwr_data,
   input  logic                         twr_en,
   input  logic [WAY_W-1:0]             twr_way,
   input  logic [TAG_W-1:0]             twr_tag,
   input  logic                         vclr_way_en,
   input  logic [WAY_W-1:0]             vclr_way,
   input  logic                         vclr_set_en
);
   logic [31:0]      dmem [NSETS][NWAYS][LW];
   logic [TAG_W-1:0] tmem [NSETS][NWAYS];
   logic [NSETS-1:0][NWAYS-1:0] vld;

   always_ff @(posedge clk) begin
      if (dwr_en) dmem[idx][dwr_way][dwr_wofs] <= dwr_data;
      if (twr_en) tmem[idx][twr_way] <= twr_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
      end else begin
         if (twr_en) vld[idx][twr_way] <= 1'b1;
         if (vclr_way_en) vld[idx][vclr_way] <= 1'b0;
         if (vclr_set_en) vld[idx] <= '0;
      end
   end

   for (genvar w = 0; w < NWAYS; w++) begin : g_rd
      assign way_tag[w]  = tmem[idx][w];
      assign way_vld[w]  = vld[idx][w];
      assign way_word[w] = dmem[idx][w][wofs];
   end
endmodule

// File: rtl/dcwt_lru.sv
module dcwt_lru
   import dcwt_pkg::*;
#(
   parameter int NSETS   = 4,
   parameter int NWAYS   = 2,
   parameter int USTATES = 4,
   localparam int IDX_W = $clog2(NSETS),
   localparam int WAY_W = $clog2(NWAYS),
   localparam int CW    = $clog2(USTATES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  lru_op_e          op,
   input  logic [WAY_W-1:0] way,
   output logic [WAY_W-1:0] victim
);
   localparam logic [CW-1:0] TOP = CW'(USTATES - 1);

   logic [NSETS-1:0][NWAYS-1:0][CW-1:0] cnt;
   logic [NWAYS-1:0][CW-1:0]            cur, nxt;

   assign cur = cnt[idx];

   always_comb begin
      logic [CW-1:0] minv;
      minv   = TOP;
      victim = '0;
      for (int i = 0; i < NWAYS; i++) begin
         if (cur[i] < minv) begin
            minv   = cur[i];
            victim = WAY_W'(i);
         end
      end
   end

   always_comb begin
      nxt = cur;
      for (int i = 0; i < NWAYS; i++) begin
         case (op)
            LRU_HIT: begin
               if (WAY_W'(i) == way)       nxt[i] = TOP;
               else if (cur[i] > cur[way]) nxt[i] = cur[i] - 1'b1;
            end
            LRU_FILL: begin
               if (WAY_W'(i) == way)       nxt[i] = TOP;
               else if (cur[i] != '0)      nxt[i] = cur[i] - 1'b1;
            end
            LRU_CLR_WAY: if (WAY_W'(i) == way) nxt[i] = '0;
            LRU_CLR_SET: nxt[i] = '0;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt      <= '0;
      else if (op != LRU_NONE)   cnt[idx] <= nxt;
   end
endmodule

// File: rtl/dcwt_cache.sv
module dcwt_cache
   import dcwt_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NSETS   = 4,
   parameter int NWAYS   = 2,
   parameter int LW      = 4,
   parameter int USTATES = 4,
   parameter bit PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic              cpu_inv,
   input  logic              cpu_en,
   input  logic              cpu_inhibit,
   input  logic [1:0]        cpu_size,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [31:0]       cpu_wdata,
   output logic              cpu_busy,
   output logic              cpu_done,
   output logic [31:0]       cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic [31:0]       cfg_info
);
   localparam int IDX_W = $clog2(NSETS);
   localparam int WAY_W = $clog2(NWAYS);
   localparam int WO_W  = $clog2(LW);
   localparam int OFF_W = WO_W + 2;
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

   if (NSETS < 2 || (NSETS & (NSETS - 1)) != 0) begin : g_bad_sets
      $error("NSETS must be a power of two, at least 2");
   end
   if (NWAYS < 2 || (NWAYS & (NWAYS - 1)) != 0 || NWAYS > 128) begin : g_bad_ways
      $error("NWAYS must be a power of two between 2 and 128");
   end
   if (LW < 2 || (LW & (LW - 1)) != 0) begin : g_bad_lw
      $error("LW must be a power of two, at least 2");
   end
   if (USTATES < 2 || USTATES > 4) begin : g_bad_ust
      $error("USTATES must be 2 to 4");
   end
   if (IDX_W > 15 || TAG_W < 1) begin : g_bad_addr
      $error("address too narrow for geometry");
   end

   assign cfg_info = (32'(IDX_W) << 3) | 32'(WAY_W);

   state_e            state;
   logic              r_we, r_inv, r_en, r_inh, r_alloc;
   logic [1:0]        r_size;
   logic [ADDR_W-1:0] r_addr;
   logic [31:0]       r_wdata, r_rdata;
   logic [WO_W-1:0]   cnt;
   logic [WAY_W-1:0]  r_victim;

   logic [IDX_W-1:0]  a_idx;
   logic [TAG_W-1:0]  a_tag;
   logic [WO_W-1:0]   a_wofs, fill_wofs;
   logic              cacheable, hit, fill_last;
   logic [WAY_W-1:0]  hit_way, victim;
   logic [NWAYS-1:0]  hit_vec;
   logic [3:0]        st_be;

   logic [NWAYS-1:0][TAG_W-1:0] way_tag;
   logic [NWAYS-1:0]            way_vld;
   logic [NWAYS-1:0][31:0]      way_word;

   logic             dwr_en, twr_en, vclr_way_en, vclr_set_en;
   logic [WAY_W-1:0] dwr_way, lru_way;
   logic [WO_W-1:0]  dwr_wofs;
   logic [31:0]      dwr_data;
   lru_op_e          lru_op;

   assign a_idx     = r_addr[OFF_W +: IDX_W];
   assign a_tag     = r_addr[ADDR_W-1 -: TAG_W];
   assign a_wofs    = r_addr[2 +: WO_W];
   assign fill_wofs = a_wofs + cnt;
   assign fill_last = (cnt == WO_W'(LW - 1));
   assign cacheable = PRESENT && r_en && !r_inh;
   assign st_be     = lane_be(r_addr[1:0], r_size);

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < NWAYS; w++) begin
         hit_vec[w] = way_vld[w] && (way_tag[w] == a_tag);
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
      hit = |hit_vec;
   end

   // storage variant chosen by PRESENT
   if (PRESENT) begin : g_store
      dcwt_arrays #(.NSETS(NSETS), .NWAYS(NWAYS), .LW(LW), .TAG_W(TAG_W)) i_arrays (
         .clk(clk), .rst_n(rst_n), .idx(a_idx), .wofs(a_wofs),
         .way_tag(way_tag), .way_vld(way_vld), .way_word(way_word),
         .dwr_en(dwr_en), .dwr_way(dwr_way), .dwr_wofs(dwr_wofs), .dwr_data(dwr_data),
         .twr_en(twr_en), .twr_way(r_victim), .twr_tag(a_tag),
         .vclr_way_en(vclr_way_en), .vclr_way(hit_way), .vclr_set_en(vclr_set_en));
      dcwt_lru #(.NSETS(NSETS), .NWAYS(NWAYS), .USTATES(USTATES)) i_lru (
         .clk(clk), .rst_n(rst_n), .idx(a_idx), .op(lru_op), .way(lru_way),
         .victim(victim));
   end else begin : g_nostore
      assign way_tag  = '0;
      assign way_vld  = '0;
      assign way_word = '0;
      assign victim   = '0;
   end

   // array and recency control
   always_comb begin
      dwr_en      = 1'b0;
      dwr_way     = hit_way;
      dwr_wofs    = a_wofs;
      dwr_data    = mem_rdata;
      twr_en      = 1'b0;
      vclr_way_en = 1'b0;
      vclr_set_en = 1'b0;
      lru_op      = LRU_NONE;
      lru_way     = hit_way;
      case (state)
         ST_LOOK: begin
            if (r_inv) begin
               if (PRESENT && !r_en) begin
                  vclr_set_en = 1'b1;
                  lru_op      = LRU_CLR_SET;
               end else if (hit) begin
                  vclr_way_en = 1'b1;
                  lru_op      = LRU_CLR_WAY;
               end
            end else if (cacheable && hit) begin
               lru_op = LRU_HIT;
               if (r_we) begin
                  dwr_en   = 1'b1;
                  dwr_data = (way_word[hit_way] & ~lane_mask(st_be)) |
                             (lane_put(r_wdata, r_size) & lane_mask(st_be));
               end
            end
         end
         ST_FILL: begin
            if (mem_ack) begin
               dwr_en   = 1'b1;
               dwr_way  = r_victim;
               dwr_wofs = fill_wofs;
               if (fill_last) begin
                  twr_en  = 1'b1;
                  lru_op  = LRU_FILL;
                  lru_way = r_victim;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         r_we     <= 1'b0;
         r_inv    <= 1'b0;
         r_en     <= 1'b0;
         r_inh    <= 1'b0;
         r_alloc  <= 1'b0;
         r_size   <= 2'd0;
         r_addr   <= '0;
         r_wdata  <= '0;
         r_rdata  <= '0;
         cnt      <= '0;
         r_victim <= '0;
      end else begin
         case (state)
            ST_IDLE: if (cpu_req) begin
               r_we    <= cpu_we;
               r_inv   <= cpu_inv;
               r_en    <= cpu_en;
               r_inh   <= cpu_inhibit;
               r_size  <= cpu_size;
               r_addr  <= cpu_addr;
               r_wdata <= cpu_wdata;
               r_alloc <= 1'b0;
               r_rdata <= '0;
               state   <= ST_LOOK;
            end
            ST_LOOK: begin
               cnt      <= '0;
               r_victim <= victim;
               if (r_inv) begin
                  state <= ST_RESP;
               end else if (!cacheable) begin
                  state <= r_we ? ST_MWR : ST_MRD;
               end else if (hit) begin
                  if (r_we) state <= ST_MWR;
                  else begin
                     r_rdata <= lane_get(way_word[hit_way], r_addr[1:0], r_size);
                     state   <= ST_RESP;
                  end
               end else if (r_we) begin
                  r_alloc <= 1'b1;
                  state   <= ST_MWR;
               end else begin
                  state <= ST_FILL;
               end
            end
            ST_MRD: if (mem_ack) begin
               r_rdata <= lane_get(mem_rdata, r_addr[1:0], r_size);
               state   <= ST_RESP;
            end
            ST_MWR: if (mem_ack) state <= r_alloc ? ST_FILL : ST_RESP;
            ST_FILL: if (mem_ack) begin
               if (cnt == '0 && !r_we)
                  r_rdata <= lane_get(mem_rdata, r_addr[1:0], r_size);
               cnt <= cnt + 1'b1;
               if (fill_last) state <= ST_RESP;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cpu_busy  = (state != ST_IDLE) && (state != ST_RESP);
   assign cpu_done  = (state == ST_RESP);
   assign cpu_rdata = r_rdata;
   assign mem_req   = (state == ST_MRD) || (state == ST_MWR) || (state == ST_FILL);
   assign mem_we    = (state == ST_MWR);
   assign mem_be    = (state == ST_MWR) ? st_be : 4'hF;
   assign mem_wdata = lane_put(r_wdata, r_size);
   assign mem_addr  = (state == ST_FILL) ?
                      {r_addr[ADDR_W-1:OFF_W], fill_wofs, 2'b00} :
                      {r_addr[ADDR_W-1:2], 2'b00};
endmodule

// File: rtl/dcwt_checker.sv
module dcwt_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_busy,
   input logic              cpu_done,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [3:0]        mem_be
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);                                    // R13
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !cpu_busy);                                    // R13
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5
   AST_MEM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cpu_busy);                                      // R2
   AST_WRITE_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_be != 4'h0));                  // R3
   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));                      // R5
endmodule

bind dcwt_cache dcwt_checker #(.ADDR_W(ADDR_W)) i_dcwt_checker (
   .clk(clk), .rst_n(rst_n), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
   .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
   .mem_addr(mem_addr), .mem_be(mem_be));

// File: tb/test_dcwt_cache.sv
`timescale 1ns/1ps
module test_dcwt_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 0, cpu_we = 0, cpu_inv = 0, cpu_en = 1, cpu_inhibit = 0;
   logic [1:0]  cpu_size = 2;
   logic [31:0] cpu_addr = 0, cpu_wdata = 0;
   logic        cpu_busy, cpu_done, mem_req, mem_we;
   logic [31:0] cpu_rdata, mem_addr, mem_wdata, cfg_info;
   logic [3:0]  mem_be;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_chk = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0;
   logic [31:0] model [256];
   logic [31:0] rd_log [16];
   logic [3:0]  last_be;
   logic [31:0] last_wd, got;
   bit          finished = 0;

   always #4 clk = ~clk;   // 125 MHz

   dcwt_cache i_dcwt_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_inv(cpu_inv),
      .cpu_en(cpu_en), .cpu_inhibit(cpu_inhibit), .cpu_size(cpu_size),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cfg_info(cfg_info));

   // memory responder: acknowledges every other cycle
   always @(negedge clk) begin
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) model[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
            last_be = mem_be;
            last_wd = mem_wdata;
            wr_cnt++;
         end else begin
            mem_rdata <= model[mem_addr[9:2]];
            rd_log[rd_cnt[3:0]] = mem_addr;
            rd_cnt++;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   function automatic logic [31:0] pick(input logic [31:0] w, input logic [31:0] a, input logic [1:0] sz);
      if (sz == 0) return {24'd0, w[31 - 8*a[1:0] -: 8]};
      if (sz == 1) return a[1] ? {16'd0, w[15:0]} : {16'd0, w[31:16]};
      return w;
   endfunction

   task automatic acc(input bit we, input bit en, input bit inh, input bit inv,
                      input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
      int t = 0;
      @(negedge clk);
      cpu_we = we; cpu_en = en; cpu_inhibit = inh; cpu_inv = inv;
      cpu_size = sz; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
      rd_cnt = 0; wr_cnt = 0;
      do begin @(negedge clk); t++; end while (!cpu_busy && t < 50);
      cpu_req = 1'b0;
      while (!cpu_done && t < 200) begin @(negedge clk); t++; end
      got = cpu_rdata;
      chk(cpu_done, "R13 done seen", {31'd0, cpu_done}, 32'd1);
   endtask

   task automatic rd(input logic [31:0] a, input logic [1:0] sz, input int exp_reads, input string rq);
      acc(0, 1, 0, 0, sz, a, 0);
      chk(rd_cnt == exp_reads, rq, rd_cnt, exp_reads);
      chk(got == pick(model[a[9:2]], a, sz), rq, got, pick(model[a[9:2]], a, sz));
   endtask

   task automatic t_reset();
      chk(!cpu_busy && !cpu_done && !mem_req, "R13 reset outputs",
          {29'd0, cpu_busy, cpu_done, mem_req}, 0);
      chk(cfg_info == 32'h11, "R10 geometry", cfg_info, 32'h11);
   endtask

   task automatic t_read_miss();
      rd(32'h048, 2, 4, "R11 first read misses");
      chk(rd_log[0] == 32'h48 && rd_log[1] == 32'h4C, "R5 critical first", rd_log[1], 32'h4C);
      chk(rd_log[2] == 32'h40 && rd_log[3] == 32'h44, "R5 wrap", rd_log[3], 32'h44);
      @(negedge clk);
      chk(!cpu_done, "R13 done one cycle", {31'd0, cpu_done}, 0);
      rd(32'h010, 2, 4, "R1 set1 line fill");
   endtask

   task automatic t_lanes();
      rd(32'h042, 1, 0, "R6 half lower lanes");
      rd(32'h040, 1, 0, "R6 half upper lanes");
      rd(32'h041, 0, 0, "R6 byte 1");
      rd(32'h043, 0, 0, "R6 byte 3");
      rd(32'h04C, 2, 0, "R1 hit no read");
   endtask

   task automatic t_store_hit();
      logic [31:0] old;
      old = model[32'h044 >> 2];
      acc(1, 1, 0, 0, 0, 32'h045, 32'h0000_00EE);
      chk(wr_cnt == 1 && rd_cnt == 0, "R3 store hit writes once", wr_cnt, 1);
      chk(last_be == 4'b0100, "R3 byte enable", {28'd0, last_be}, 32'h4);
      acc(0, 1, 0, 0, 2, 32'h044, 0);
      chk(got == ((old & 32'hFF00_FFFF) | 32'h00EE_0000), "R7 byte merge", got,
          (old & 32'hFF00_FFFF) | 32'h00EE_0000);
      old = model[32'h010 >> 2];
      acc(1, 1, 0, 0, 1, 32'h012, 32'h0000_BEEF);
      chk(last_be == 4'b0011, "R3 half enable", {28'd0, last_be}, 32'h3);
      acc(0, 1, 0, 0, 2, 32'h010, 0);
      chk(got == {old[31:16], 16'hBEEF} && rd_cnt == 0, "R7 half merge", got, {old[31:16], 16'hBEEF});
   endtask

   task automatic t_write_miss();
      acc(1, 1, 0, 0, 2, 32'h108, 32'h1234_5678);
      chk(wr_cnt == 1 && rd_cnt == 4, "R4 allocate on store miss", rd_cnt, 4);
      acc(0, 1, 0, 0, 2, 32'h108, 0);
      chk(rd_cnt == 0 && got == 32'h1234_5678, "R4 stored data hits", got, 32'h1234_5678);
   endtask

   task automatic t_lru();
      rd(32'h040, 2, 0, "R12 refresh line A");
      rd(32'h180, 2, 4, "R12 new line C");
      rd(32'h040, 2, 0, "R12 recent line kept");
      rd(32'h100, 2, 4, "R12 older line evicted");
   endtask

   task automatic t_bypass();
      acc(0, 1, 1, 0, 2, 32'h200, 0);
      chk(rd_cnt == 1 && got == model[32'h200 >> 2], "R2 inhibited read", got, model[32'h200 >> 2]);
      acc(0, 0, 0, 0, 1, 32'h244, 0);
      chk(rd_cnt == 1 && got == pick(model[32'h244 >> 2], 32'h244, 1), "R2 disabled read", got,
          pick(model[32'h244 >> 2], 32'h244, 1));
      acc(1, 0, 0, 0, 0, 32'h300, 32'h77);
      chk(wr_cnt == 1 && rd_cnt == 0, "R3 uncached store", wr_cnt, 1);
      rd(32'h040, 2, 0, "R2 line A unchanged");
      rd(32'h100, 2, 0, "R2 line B unchanged");
   endtask

   task automatic t_inv();
      acc(0, 1, 0, 1, 2, 32'h3C0, 0);
      rd(32'h044, 2, 0, "R8 invalidate miss no effect A");
      rd(32'h104, 2, 0, "R8 invalidate miss no effect B");
      acc(0, 1, 0, 1, 2, 32'h104, 0);
      chk(rd_cnt == 0 && wr_cnt == 0, "R8 invalidate no memory", rd_cnt, 0);
      rd(32'h100, 2, 4, "R8 invalidated line misses");
      rd(32'h040, 2, 0, "R8 other way kept");
   endtask

   task automatic t_inv_disabled();
      acc(0, 0, 0, 1, 2, 32'h000, 0);
      rd(32'h040, 2, 4, "R9 set cleared way A");
      rd(32'h100, 2, 4, "R9 set cleared way B");
      rd(32'h010, 2, 0, "R9 other set kept");
   endtask

   initial begin
      for (int i = 0; i < 256; i++)
         model[i] = {i[7:0] ^ 8'hA5, i[7:0], i[7:0] ^ 8'h3C, ~i[7:0]};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_miss();
      t_lanes();
      t_store_hit();
      t_write_miss();
      t_lru();
      t_bypass();
      t_inv();
      t_inv_disabled();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule